// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a clean vertical sync from a one-bit digital composite sync that carries both line and frame sync. Each active pulse is timed by a saturating duration counter running on a 40 MHz reference clock. Short pulses are removed entirely: line syncs, equalization pulses and noise. A pulse that lasts longer than a programmable threshold appears at the output. The output leading edge comes only once the pulse has lasted the threshold, so the result lags the input by that threshold.

The threshold `thresh` is an unsigned value N counted in 200 ns units. At 40 MHz one unit is 8 reference cycles, so the limit is N×8 cycles; N = 5 gives 1 µs. The input passes through a two-flop synchronizer before it is timed. The active level is low by default, and a parameter selects active-high instead. An enable input holds the output low and the counter cleared while it is deasserted.

Top module: `csvs_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `vsync_out` is 0.
- R2: An active pulse seen on `csync_in` for L consecutive clock edges with L ≤ N×8 produces no high cycle on `vsync_out`.
- R3: For a pulse with L > N×8, `vsync_out` rises on clock edge k+2+N×8, where k is the first edge that samples `csync_in` active. This is the synchronizer latency plus exactly the threshold.
- R4: `vsync_out` falls on the second clock edge after `csync_in` is first sampled inactive. A passing pulse therefore gives an output L − N×8 cycles wide.
- R5: With N = 0, every active pulse passes, even one of a single cycle. The output has the same width as the input pulse and a latency of two edges.
- R6: While `en` is 0, `vsync_out` stays 0 whatever `csync_in` does.
- R7: A pulse longer than the counter range keeps `vsync_out` high until the pulse ends. The counter saturates and does not wrap; checked with N = 255 (limit 2040 cycles) and a 3000-cycle pulse.
- R8: With the default polarity, `csync_in` = 0 is active and `csync_in` = 1 is idle. An idle level held for any length produces no output.
- R9: A single inactive cycle clears the duration count. Short pulses separated by one idle cycle never add up to a passing pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; when 0 the output is forced low and the count is cleared |
| thresh | input | 8 | Duration threshold N in 200 ns units (N×8 cycles) |
| csync_in | input | 1 | Asynchronous composite sync, active-low by default |
| vsync_out | output | 1 | Recovered vertical sync, active-high |

## Verification
Two events can fall on the same clock edge: the count reaching the limit and the pulse ending. The bench provokes this with pulses of exactly N×8 edges and of N×8+1 edges. It judges that the first gives no output and the second gives a single high cycle at edge k+2+N×8. The same collision is driven at N = 0, where a one-edge pulse must still pass. It is driven again at the saturation end, where the count stops at its maximum while the pulse continues and the output must stay high.

// File: rtl/csvs_pkg.sv
package csvs_pkg;

    // Reference clock cycles in one 200 ns threshold unit (40 MHz tick).
    localparam int unsigned UNIT_TICKS = 8;
    // Width of the threshold value N.
    localparam int unsigned THR_W      = 8;
    localparam int unsigned UNIT_BITS  = $clog2(UNIT_TICKS);
    // Counter wide enough to hold the largest limit, (2^THR_W - 1) * UNIT_TICKS.
    localparam int unsigned CNT_W      = THR_W + UNIT_BITS;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    // State of the duration counter seen by the qualifier.
    typedef struct packed {
        cnt_t count;   // active cycles seen so far in the current pulse
        logic sat;     // counter is parked at its maximum
    } dur_t;

    // Convert a threshold in units to a limit in reference cycles.
    function automatic cnt_t limit_of(input thr_t n);
        return cnt_t'(n) * cnt_t'(UNIT_TICKS);
    endfunction

endpackage

// File: rtl/csvs_sync.sv
module csvs_sync #(
    parameter bit          ACTIVE_LOW = 1'b1,
    parameter int unsigned STAGES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic active
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              norm;

    // Normalize polarity first so the reset value always means idle.
    assign norm = ACTIVE_LOW ? ~raw_in : raw_in;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= norm;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign active = chain[LAST];

    AST_SYNC_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !active); // R1

endmodule

// File: rtl/csvs_dur_cnt.sv
module csvs_dur_cnt
    import csvs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic active,
    output dur_t dur
);
    cnt_t count_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !active) begin
            count_q <= '0;
        end else if (count_q != CNT_MAX) begin
            count_q <= count_q + cnt_t'(1);
        end
    end

    assign dur.count = count_q;
    assign dur.sat   = (count_q == CNT_MAX);

    AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> (dur.count == '0)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && active && dur.sat) |=> dur.sat); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && active && !dur.sat) |=> (dur.count == $past(dur.count) + cnt_t'(1))); // R3

endmodule

// File: rtl/csvs_qual.sv
module csvs_qual
    import csvs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic active,
    input  thr_t thresh,
    input  dur_t dur,
    output logic vsync
);
    cnt_t limit;
    logic pass;

    assign limit = limit_of(thresh);
    assign pass  = en && active && (dur.count >= limit);

    always_ff @(posedge clk) begin
        if (rst) vsync <= 1'b0;
        else     vsync <= pass;
    end

    AST_RISE_AFTER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> ($past(dur.count) >= $past(limit))); // R2

    AST_EN_GATES: assert property (@(posedge clk) disable iff (rst)
        !en |=> !vsync); // R6

    AST_DROP_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !vsync); // R4

endmodule

// File: rtl/csvs_top.sv
module csvs_top
    import csvs_pkg::*;
#(
    parameter bit          ACTIVE_LOW  = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [THR_W-1:0] thresh,
    input  logic             csync_in,
    output logic             vsync_out
);
    logic active;
    dur_t dur;

    csvs_sync #(
        .ACTIVE_LOW (ACTIVE_LOW),
        .STAGES     (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (csync_in),
        .active (active)
    );

    csvs_dur_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .active (active),
        .dur    (dur)
    );

    csvs_qual u_qual (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .active (active),
        .thresh (thresh),
        .dur    (dur),
        .vsync  (vsync_out)
    );

    AST_OUT_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !vsync_out); // R1

    AST_ZERO_THR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0 && $past(thresh) == '0 && en && $past(en))
            |-> (vsync_out == $past(active))); // R5

endmodule

// File: tb/sim_csvs_top.sv
module sim_csvs_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [7:0] thresh = '0;
    logic       csync_in = 1'b1;
    logic       vsync_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    csvs_top u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .thresh    (thresh),
        .csync_in  (csync_in),
        .vsync_out (vsync_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one active-low pulse of len edges under threshold n; check first
    // high sample and width. Drive at iteration c shows at iteration c+3+lim.
    task automatic run_pulse(input string req, input int n, input int len);
        int lim   = n * 8;
        int first = -1;
        int width = 0;
        thresh = n[7:0];
        for (int c = 0; c < len + lim + 8; c++) begin
            @(negedge clk);
            if (vsync_out) begin
                if (first < 0) first = c;
                width++;
            end
            csync_in = (c < len) ? 1'b0 : 1'b1;
        end
        if (len > lim) begin
            check({req, " width"}, width, len - lim);
            check({req, " first"}, first, 3 + lim);
        end else begin
            check({req, " suppressed"}, width, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 during reset", int'(vsync_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'(vsync_out), 0);
    endtask

    task automatic t_idle_high();
        int seen = 0;
        thresh = 8'd0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            csync_in = 1'b1;
            if (vsync_out) seen++;
        end
        check("R8 idle level", seen, 0);
    endtask

    task automatic t_train();
        int seen = 0;
        thresh = 8'd1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (vsync_out) seen++;
            csync_in = ((c % 7) == 6 || c >= 70) ? 1'b1 : 1'b0;
        end
        check("R9 train of short pulses", seen, 0);
    endtask

    task automatic t_enable();
        int seen = 0;
        thresh = 8'd1;
        en = 1'b0;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (vsync_out) seen++;
            csync_in = (c < 100) ? 1'b0 : 1'b1;
        end
        en = 1'b1;
        check("R6 disabled", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle_high();
        run_pulse("R2 N5 len40", 5, 40);
        run_pulse("R3 N5 len41", 5, 41);
        run_pulse("R4 N5 len200", 5, 200);
        run_pulse("R3 N2 len100", 2, 100);
        run_pulse("R2 N2 len16", 2, 16);
        run_pulse("R5 N0 len1", 0, 1);
        run_pulse("R5 N0 len7", 0, 7);
        t_train();
        t_enable();
        run_pulse("R8 N1 active low", 1, 30);
        run_pulse("R7 N255 len3000", 255, 3000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule